// File: doc/BRIEF.md
# Polled or Direct Status-Bus Sequencer

This block decides when one device puts its four per-queue almost-empty status bits onto a status bus that several devices share. Everything runs on the read clock. The mode is latched while master reset is held and stays fixed afterwards.

In polled mode the chained devices pass a one-cycle token around a ring. A device drives the bus for the read-clock cycle that follows the edge at which it sampled the token on its expansion input. During that cycle it raises a sync pulse and a token output, and the next device in the ring picks up the token from that output. In direct mode a strobe, qualified by a programming-done input, selects a device by address. The selected device keeps driving until a later qualified strobe names another address.

Top module: `status_bus_seq`

## Requirements
- R1: `mode_pin` is sampled on every clock edge while `rst_n` is low. A 1 selects polled mode and a 0 selects direct mode. Changes on `mode_pin` after reset release have no effect on behaviour.
- R2: In polled mode, `stat_oe` in the cycle after a rising edge equals `tok_in` as sampled at that edge. A device that wires `tok_out` back to `tok_in` therefore keeps driving every cycle.
- R3: While `stat_oe` is 1, `stat_bus` holds the `stat_in` value sampled at the edge that made the device drive. In direct mode that value is refreshed on every edge while the device stays selected.
- R4: In polled mode, `sync_out` and `tok_out` are 1 exactly in the cycles where `stat_oe` is 1.
- R5: In direct mode, an edge with `strobe`=1 and `prog_done`=1 selects the device when `dev_addr` equals `DEV_ID` and deselects it otherwise. Without such a strobe the selection holds.
- R6: In direct mode, `strobe` has no effect while `prog_done` is 0.
- R7: In polled mode `strobe`, `dev_addr` and `prog_done` have no effect. In direct mode `tok_in` has no effect, and `sync_out` and `tok_out` stay 0.
- R8: Whenever `stat_oe` is 0, `stat_bus` is all zeros.
- R9: A device with parameter `FIRST_IN_RING`=1 that is reset in polled mode drives, with `stat_oe`=1, during reset and in the first cycle after release. A device reset in direct mode comes out of reset deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| mode_pin | input | 1 | Flag-mode strap: 1 polled, 0 direct |
| tok_in | input | 1 | Ring token from the previous device |
| strobe | input | 1 | Direct-mode select strobe |
| dev_addr | input | ADDR_W | Direct-mode device address |
| prog_done | input | 1 | Programming finished; qualifies the strobe |
| stat_in | input | NQ | Per-queue almost-empty status |
| stat_bus | output | NQ | Status bus data, zero when not driving |
| stat_oe | output | 1 | Bus output enable (low means high-impedance) |
| sync_out | output | 1 | High during this device's polled turn |
| tok_out | output | 1 | Token passed to the next device |

## Verification
The assertions assume that `mode_pin` is steady during the last reset edge and that `tok_in` and `strobe` meet setup at each rising edge. They do not assume that the unused input of each mode is held low. The stimulus therefore deliberately toggles `strobe` in polled mode and `tok_in` in direct mode, to show that those inputs are ignored. All inputs change only on falling edges. Strobes are issued both before and after `prog_done` rises, with matching and non-matching addresses. Both a bench-driven token and a looped-back token are used.

// File: rtl/sbs_pkg.sv
// Package: shared types for the status-bus sequencer.
package sbs_pkg;
    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_POLLED = 1'b1
    } bus_mode_e;
endpackage

// File: rtl/sbs_mode_latch.sv
// Latches the bus mode from the strap pin while reset is held.
// Assumes the strap is steady across the final reset edge.
module sbs_mode_latch
    import sbs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_pin,
    output bus_mode_e mode_q,
    output logic      polled_eff
);
    // Capture the strap on every reset edge; hold afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= bus_mode_e'(mode_pin);
    end

    // During reset the strap itself decides; afterwards the latched mode does.
    always_comb polled_eff = rst_n ? (mode_q == MODE_POLLED) : mode_pin;

    // R1: mode never changes outside reset
    p_mode_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/sbs_ring_stage.sv
// One stage of the polled token ring. Holds the "my turn" flag,
// which is loaded from the token input at each edge. Assumes polled_i
// reflects the strap during reset and the latched mode afterwards.
module sbs_ring_stage #(
    parameter bit FIRST_IN_RING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic polled_i,
    input  logic tok_in,
    output logic turn_nxt,
    output logic turn_q
);
    // Next-turn value: seeded at reset for the first device, else the token.
    always_comb begin
        if (!rst_n)        turn_nxt = FIRST_IN_RING && polled_i;
        else if (polled_i) turn_nxt = tok_in;
        else               turn_nxt = 1'b0;
    end

    // Turn register.
    always_ff @(posedge clk) begin
        turn_q <= turn_nxt;
    end

    // R2: in polled mode the turn follows the sampled token one edge later
    p_ring_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        polled_i |=> (turn_q == $past(tok_in)));
endmodule

// File: rtl/sbs_direct_select.sv
// Direct-mode address select. A strobe qualified by programming-done
// selects the device if the address matches and deselects it otherwise.
// Assumes dev_addr is valid whenever strobe is high.
module sbs_direct_select #(
    parameter int ADDR_W = 3,
    parameter int DEV_ID = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              direct_i,
    input  logic              strobe,
    input  logic              prog_done,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              sel_nxt,
    output logic              sel_q
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DEV_ID);

    logic strobe_ok;

    // A strobe only counts in direct mode after programming completes.
    always_comb strobe_ok = direct_i && strobe && prog_done;

    // Next selection: cleared in reset, updated by a qualified strobe.
    always_comb begin
        if (!rst_n)         sel_nxt = 1'b0;
        else if (!direct_i) sel_nxt = 1'b0;
        else if (strobe_ok) sel_nxt = (dev_addr == MY_ADDR);
        else                sel_nxt = sel_q;
    end

    // Selection register.
    always_ff @(posedge clk) begin
        sel_q <= sel_nxt;
    end

    // R6: without programming-done the selection cannot move
    p_locked_until_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_i && !prog_done) |=> $stable(sel_q));
endmodule

// File: rtl/sbs_bus_drive.sv
// Bus driver stage. Captures status when a turn or selection begins
// (and every edge while selected in direct mode) and gates the bus,
// the enable and the polled handshake outputs.
module sbs_bus_drive #(
    parameter int NQ = 4
) (
    input  logic          clk,
    input  logic          polled_i,
    input  logic          load_i,
    input  logic          drive_i,
    input  logic [NQ-1:0] stat_in,
    output logic [NQ-1:0] stat_bus,
    output logic          stat_oe,
    output logic          sync_out,
    output logic          tok_out
);
    logic [NQ-1:0] hold_q;

    // Capture status at the edge that starts or continues a drive.
    always_ff @(posedge clk) begin
        if (load_i) hold_q <= stat_in;
    end

    // Gate bus data and handshakes with the drive flag.
    always_comb begin
        stat_oe  = drive_i;
        stat_bus = drive_i ? hold_q : '0;
        sync_out = drive_i && polled_i;
        tok_out  = drive_i && polled_i;
    end
endmodule

// File: rtl/status_bus_seq.sv
// Top level: chooses between the token ring and the address select
// according to the latched mode and drives the shared status bus.
// Assumes: synchronous active-low reset of at least one clock.
module status_bus_seq
    import sbs_pkg::*;
#(
    parameter int ADDR_W        = 3,
    parameter int DEV_ID        = 2,
    parameter int NQ            = 4,
    parameter bit FIRST_IN_RING = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pin,
    input  logic              tok_in,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              prog_done,
    input  logic [NQ-1:0]     stat_in,
    output logic [NQ-1:0]     stat_bus,
    output logic              stat_oe,
    output logic              sync_out,
    output logic              tok_out
);
    bus_mode_e mode_q;
    logic      polled_eff;
    logic      turn_nxt, turn_q;
    logic      sel_nxt, sel_q;
    logic      load, drive;

    sbs_mode_latch u_mode (
        .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin),
        .mode_q(mode_q), .polled_eff(polled_eff)
    );

    sbs_ring_stage #(.FIRST_IN_RING(FIRST_IN_RING)) u_ring (
        .clk(clk), .rst_n(rst_n), .polled_i(polled_eff), .tok_in(tok_in),
        .turn_nxt(turn_nxt), .turn_q(turn_q)
    );

    sbs_direct_select #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_sel (
        .clk(clk), .rst_n(rst_n), .direct_i(!polled_eff), .strobe(strobe),
        .prog_done(prog_done), .dev_addr(dev_addr),
        .sel_nxt(sel_nxt), .sel_q(sel_q)
    );

    // Pick the source of the drive flag by mode.
    always_comb begin
        load  = polled_eff ? turn_nxt : sel_nxt;
        drive = polled_eff ? turn_q   : sel_q;
    end

    sbs_bus_drive #(.NQ(NQ)) u_drv (
        .clk(clk), .polled_i(polled_eff), .load_i(load), .drive_i(drive),
        .stat_in(stat_in), .stat_bus(stat_bus), .stat_oe(stat_oe),
        .sync_out(sync_out), .tok_out(tok_out)
    );

    // R4: sync pulse only while this device owns the bus
    p_sync_owns_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> stat_oe);

    // R7: direct mode never emits a token or sync
    p_direct_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DIRECT) |-> (!tok_out && !sync_out));

    // R8: an idle bus carries no data
    p_idle_bus_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_oe |-> (stat_bus == '0));
endmodule

// File: tb/status_bus_seq_tb_top.sv
module status_bus_seq_tb_top;
    localparam int AW = 3;
    localparam int ID = 2;
    localparam int NQ = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_pin = 1'b1;
    logic tb_tok = 1'b0;
    logic loop_en = 1'b0;
    logic strobe = 1'b0;
    logic [AW-1:0] dev_addr = '0;
    logic prog_done = 1'b0;
    logic [NQ-1:0] stat_in = '0;
    logic [NQ-1:0] stat_bus;
    logic stat_oe, sync_out, tok_out, tok_in;

    int errors = 0;
    int checks = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;
    string cur_req = "R9";

    assign tok_in = loop_en ? tok_out : tb_tok;

    always #5 clk = ~clk;

    status_bus_seq #(.ADDR_W(AW), .DEV_ID(ID), .NQ(NQ), .FIRST_IN_RING(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .tok_in(tok_in),
        .strobe(strobe), .dev_addr(dev_addr), .prog_done(prog_done),
        .stat_in(stat_in), .stat_bus(stat_bus), .stat_oe(stat_oe),
        .sync_out(sync_out), .tok_out(tok_out)
    );

    // Behavioural reference: mode, who-drives flag, captured status.
    bit m_pol = 1'b0;
    bit m_drv = 1'b0;
    logic [NQ-1:0] m_hold = '0;

    always @(posedge clk) begin
        bit nxt;
        if (!rst_n) begin
            m_pol = mode_pin;
            nxt = mode_pin;
        end else if (m_pol) begin
            nxt = tok_in;
        end else if (strobe && prog_done) begin
            nxt = (dev_addr == AW'(ID));
        end else begin
            nxt = m_drv;
        end
        if (nxt) m_hold = stat_in;
        m_drv = nxt;
    end

    task automatic check1(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, well after the edge.
    always @(posedge clk) begin
        #3;
        if (chk_en) begin
            check1("stat_oe", int'(stat_oe), int'(m_drv));
            check1("stat_bus (R8 when idle)", int'(stat_bus), m_drv ? int'(m_hold) : 0);
            check1("sync_out", int'(sync_out), int'(m_drv && m_pol));
            check1("tok_out", int'(tok_out), int'(m_drv && m_pol));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200_000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R9: polled reset, first device owns the token
        step(1);
        chk_en = 1'b1;
        cur_req = "R9";
        step(2);
        rst_n = 1'b1;
        stat_in = 4'h5;
        step(1);
        // R2/R3: bench-driven token pulses, varying status
        cur_req = "R2";
        for (int i = 0; i < 20; i++) begin
            tb_tok = (i % 3 == 0);
            stat_in = 4'(i * 7 + 3);
            step(1);
        end
        tb_tok = 1'b0;
        // R7: strobe and address in polled mode must not matter
        cur_req = "R7";
        prog_done = 1'b1;
        for (int i = 0; i < 10; i++) begin
            strobe = i[0];
            dev_addr = AW'(ID);
            tb_tok = (i == 4);
            stat_in = 4'(i);
            step(1);
        end
        strobe = 1'b0;
        // R1: strap change after reset has no effect
        cur_req = "R1";
        mode_pin = 1'b0;
        tb_tok = 1'b1;
        stat_in = 4'hA;
        step(2);
        tb_tok = 1'b0;
        step(2);
        // R2: looped token keeps the single device driving
        cur_req = "R2";
        tb_tok = 1'b1;
        step(1);
        loop_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            stat_in = 4'(15 - i);
            step(1);
        end
        loop_en = 1'b0;
        tb_tok = 1'b0;
        step(2);
        // R9: direct reset comes out deselected
        cur_req = "R9";
        prog_done = 1'b0;
        mode_pin = 1'b0;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R6: strobe ignored before programming completes
        cur_req = "R6";
        strobe = 1'b1;
        dev_addr = AW'(ID);
        step(3);
        strobe = 1'b0;
        step(1);
        // R5/R3: qualified select, refresh, deselect
        cur_req = "R5";
        prog_done = 1'b1;
        strobe = 1'b1;
        step(1);
        strobe = 1'b0;
        cur_req = "R3";
        for (int i = 0; i < 5; i++) begin
            stat_in = 4'(i + 9);
            step(1);
        end
        // R7: token input ignored in direct mode
        cur_req = "R7";
        tb_tok = 1'b1;
        step(3);
        tb_tok = 1'b0;
        cur_req = "R5";
        strobe = 1'b1;
        dev_addr = AW'(ID + 1);
        step(1);
        strobe = 1'b0;
        step(3);
        strobe = 1'b1;
        dev_addr = AW'(ID);
        stat_in = 4'h3;
        step(1);
        strobe = 1'b0;
        step(3);
        // R6: deselect blocked when programming-done drops
        cur_req = "R6";
        prog_done = 1'b0;
        strobe = 1'b1;
        dev_addr = AW'(0);
        step(3);
        strobe = 1'b0;
        step(2);
        chk_en = 1'b0;
        finish_run();
    end
endmodule